// File: doc/BRIEF.md
# Peripheral-to-Memory Byte Transfer Channel

This block moves bytes between one direction of a serial port and system memory so that the processor does not handle each character. Software programs a 32-bit memory pointer and a 16-bit transfer count through a small register write port. The channel then serves byte requests from the serial port by issuing single memory accesses. After each access completes, the pointer moves up by one and the count moves down by one.

A parameter fixes the direction. In receive form the channel takes a byte from the port and writes it to memory. In transmit form it reads a byte from memory and hands it to the port. Each serial port uses one instance of each form. When the count reaches zero the channel raises an end-of-run flag, and an interrupt if that is enabled. It then stays idle until software loads a new non-zero count.

Top module: `perdma_chan`

## Requirements
- R1: After a synchronous active-low reset, the pointer, the count, the end-of-run flag and the interrupt enable are zero, and `irq`, `mem_req` and `per_ack` are low.
- R2: A write with `reg_sel` = 0 loads all 32 bits of `reg_wdata` into the pointer. `reg_sel` = 1 loads `reg_wdata[15:0]` into the count. `reg_sel` = 2 loads `reg_wdata[0]` into the interrupt enable. `reg_sel` = 3 changes nothing. The new value shows on `ptr_out` / `cnt_out` after the write edge.
- R3: Receive form (`RX_DIR`=1): a request accepted at an edge raises `mem_req` after that edge, with `mem_we`=1, `mem_addr` equal to the pointer, and `mem_wdata` equal to `per_rdata` as sampled at the accepting edge.
- R4: Transmit form (`RX_DIR`=0): an accepted request raises `mem_req` with `mem_we`=0 and `mem_addr` equal to the pointer. The `mem_rdata` present with `mem_ack` appears on `per_wdata` after that edge.
- R5: `per_ack` is high for exactly one cycle, namely the cycle after the edge where `mem_req` and `mem_ack` are both high.
- R6: Each completed access adds one to the pointer, wrapping from 0xFFFFFFFF to 0, and subtracts one from the count.
- R7: `mem_req` stays high until `mem_ack`, so at most one memory access is outstanding. A `per_req` is not accepted while an access is outstanding or in the cycle where `per_ack` is high.
- R8: While the count is zero, `per_req` is ignored: no `mem_req`, no `per_ack`, and no change to the pointer.
- R9: The end-of-run flag is set after the edge that completes the access taking the count from 1 to 0. It stays set while the count remains zero.
- R10: A count write with a non-zero value clears the end-of-run flag at that edge. A count write of zero leaves the flag unchanged.
- R11: `irq` is high exactly when both the end-of-run flag and the interrupt enable are set.
- R12: A register write in the same cycle as an access completion takes priority for the written register. A completion that finds the count already zero does not decrement it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 pointer, 1 count, 2 interrupt enable |
| reg_wdata | input | 32 | Register write data |
| ptr_out | output | 32 | Current pointer |
| cnt_out | output | 16 | Remaining count |
| eot_flag | output | 1 | End-of-run status bit |
| irq | output | 1 | Interrupt (flag AND enable) |
| per_req | input | 1 | Serial-port byte request, held until `per_ack` |
| per_rdata | input | 8 | Byte from the port (receive form) |
| per_ack | output | 1 | One-cycle completion to the port |
| per_wdata | output | 8 | Byte to the port (transmit form) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte |
| mem_ack | input | 1 | Memory access completion |

## Verification
Both forms run side by side on the same stimulus through a sweep of run lengths 1 to 4. Within each run the memory latency cycles over 1, 2 and 3 cycles, which separates a held request from a premature completion. The port request is alternately dropped and held through the acknowledge, which tells a correct re-acceptance gap apart from a double transfer. Separate patterns cover requests at zero count, pointer wrap, zero versus non-zero count writes against the flag, the interrupt enable, and register writes colliding with a completion.

// File: rtl/perdma_pkg.sv
// Shared types and register selects for the peripheral transfer channel.
package perdma_pkg;
    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_BUSY = 1'b1
    } ch_state_e;

    localparam logic [1:0] SEL_PTR = 2'd0;
    localparam logic [1:0] SEL_CNT = 2'd1;
    localparam logic [1:0] SEL_IEN = 2'd2;
endpackage

// File: rtl/perdma_regs.sv
// Pointer, count, end-of-run flag and interrupt enable.
// Assumes xfer_done is a one-cycle pulse from the controller. A software
// write beats the hardware update of the same register in the same cycle.
module perdma_regs
    import perdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              xfer_done,
    output logic [ADDR_W-1:0] ptr_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              eot_q,
    output logic              ien_q,
    output logic              cnt_zero
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic ptr_wr, cnt_wr, ien_wr, cnt_wr_nz;

    // Decode the register write strobes.
    always_comb begin
        ptr_wr    = wr_en && (wr_sel == SEL_PTR);
        cnt_wr    = wr_en && (wr_sel == SEL_CNT);
        ien_wr    = wr_en && (wr_sel == SEL_IEN);
        cnt_wr_nz = cnt_wr && (wr_data[CNT_W-1:0] != '0);
        cnt_zero  = (cnt_q == '0);
    end

    // Pointer: software load, else advance on each completion.
    always_ff @(posedge clk) begin
        if (!rst_n)          ptr_q <= '0;
        else if (ptr_wr)     ptr_q <= wr_data;
        else if (xfer_done)  ptr_q <= ptr_q + ADDR_W'(1);
    end

    // Count: software load, else decrement on completion if non-zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (cnt_wr)                  cnt_q <= wr_data[CNT_W-1:0];
        else if (xfer_done && !cnt_zero)  cnt_q <= cnt_q - CNT_ONE;
    end

    // End-of-run flag: cleared by a non-zero count load, set by the last access.
    always_ff @(posedge clk) begin
        if (!rst_n)                               eot_q <= 1'b0;
        else if (cnt_wr_nz)                       eot_q <= 1'b0;
        else if (xfer_done && cnt_q == CNT_ONE)   eot_q <= 1'b1;
    end

    // Interrupt enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)      ien_q <= 1'b0;
        else if (ien_wr) ien_q <= wr_data[0];
    end

    // R6: a completion without a count write decrements a non-zero count.
    a_r6_cnt_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !cnt_wr && !cnt_zero) |=> (cnt_q == $past(cnt_q) - CNT_ONE));

    // R6: a completion without a pointer write advances the pointer.
    a_r6_ptr_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !ptr_wr) |=> (ptr_q == $past(ptr_q) + ADDR_W'(1)));

    // R9: the access that empties the count sets the flag.
    a_r9_eot_set: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && cnt_q == CNT_ONE && !cnt_wr) |=> eot_q);

    // R10: a non-zero count load clears the flag.
    a_r10_eot_clr: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr_nz |=> !eot_q);

    // R12: the count never wraps below zero through a completion.
    a_r12_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && cnt_zero && !cnt_wr) |=> cnt_zero);
endmodule

// File: rtl/perdma_ctrl.sv
// Handshake controller: accepts a port request, runs one memory access,
// then acknowledges the port. RX_DIR picks write-to-memory (1) or
// read-from-memory (0). Assumes per_req is held until per_ack.
module perdma_ctrl
    import perdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 8,
    parameter bit RX_DIR = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              per_req,
    input  logic [DATA_W-1:0] per_rdata,
    output logic              per_ack,
    output logic [DATA_W-1:0] per_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  logic [ADDR_W-1:0] ptr,
    input  logic              cnt_zero,
    output logic              xfer_done
);
    ch_state_e         state_q;
    logic              accept;
    logic [DATA_W-1:0] data_q;

    // Accept only when idle, counted, and not in the acknowledge cycle.
    always_comb begin
        accept    = (state_q == CH_IDLE) && per_req && !per_ack && !cnt_zero;
        xfer_done = (state_q == CH_BUSY) && mem_ack;
        mem_req   = (state_q == CH_BUSY);
        mem_we    = RX_DIR;
    end

    // One outstanding access: idle to busy on accept, back on memory ack.
    always_ff @(posedge clk) begin
        if (!rst_n)          state_q <= CH_IDLE;
        else if (accept)     state_q <= CH_BUSY;
        else if (xfer_done)  state_q <= CH_IDLE;
    end

    // Address latch and one-cycle port acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            per_ack  <= 1'b0;
        end else begin
            if (accept) mem_addr <= ptr;
            per_ack <= xfer_done;
        end
    end

    // Byte holding register, filled from the side the direction selects.
    always_ff @(posedge clk) begin
        if (!rst_n)                    data_q <= '0;
        else if (RX_DIR && accept)     data_q <= per_rdata;
        else if (!RX_DIR && xfer_done) data_q <= mem_rdata;
    end

    // Route the held byte to the side that consumes it.
    generate
        if (RX_DIR) begin : g_rx
            assign mem_wdata = data_q;
            assign per_wdata = '0;
        end else begin : g_tx
            assign mem_wdata = '0;
            assign per_wdata = data_q;
        end
    endgenerate

    // R7: an unacknowledged memory request stays up with a stable address.
    a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R5: the port acknowledge follows a memory completion.
    a_r5_ack_after_mem: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(per_ack) |-> $past(mem_req && mem_ack));

    // R5: acknowledge lasts one cycle.
    a_r5_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        per_ack |=> !per_ack);

    // R8: an idle channel with zero count starts no access.
    a_r8_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req && cnt_zero) |=> !mem_req);

    // R7: no new access starts in the acknowledge cycle.
    a_r7_no_reaccept: assert property (@(posedge clk) disable iff (!rst_n)
        per_ack |=> !mem_req);
endmodule

// File: rtl/perdma_chan.sv
// Top of the peripheral transfer channel: register file plus handshake
// controller. Combines the end-of-run flag with the interrupt enable.
module perdma_chan #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8,
    parameter bit RX_DIR = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] ptr_out,
    output logic [CNT_W-1:0]  cnt_out,
    output logic              eot_flag,
    output logic              irq,
    input  logic              per_req,
    input  logic [DATA_W-1:0] per_rdata,
    output logic              per_ack,
    output logic [DATA_W-1:0] per_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    logic xfer_done, cnt_zero, ien;

    perdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .wr_sel    (reg_sel),
        .wr_data   (reg_wdata),
        .xfer_done (xfer_done),
        .ptr_q     (ptr_out),
        .cnt_q     (cnt_out),
        .eot_q     (eot_flag),
        .ien_q     (ien),
        .cnt_zero  (cnt_zero)
    );

    perdma_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RX_DIR(RX_DIR)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .per_req   (per_req),
        .per_rdata (per_rdata),
        .per_ack   (per_ack),
        .per_wdata (per_wdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack),
        .ptr       (ptr_out),
        .cnt_zero  (cnt_zero),
        .xfer_done (xfer_done)
    );

    // Interrupt is the masked end-of-run status.
    assign irq = eot_flag & ien;

    // R11: the interrupt never rises without the end-of-run flag.
    a_r11_irq_needs_eot: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> eot_flag);
endmodule

// File: tb/perdma_chan_test.sv
// Runs a receive and a transmit channel in lockstep on shared stimulus.
module perdma_chan_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic        per_req = 1'b0;
    logic [7:0]  per_rdata = '0;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = '0;

    logic [31:0] rx_ptr, tx_ptr, rx_addr, tx_addr;
    logic [15:0] rx_cnt, tx_cnt;
    logic        rx_eot, tx_eot, rx_irq, tx_irq, rx_ack, tx_ack;
    logic        rx_mreq, tx_mreq, rx_we, tx_we;
    logic [7:0]  rx_pwd, tx_pwd, rx_mwd, tx_mwd;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    logic [31:0] exp_ptr = '0;
    logic [15:0] exp_cnt = '0;
    logic        exp_eot = 1'b0;
    logic        exp_ien = 1'b0;

    always #10 clk = ~clk;

    perdma_chan #(.RX_DIR(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ptr_out(rx_ptr), .cnt_out(rx_cnt),
        .eot_flag(rx_eot), .irq(rx_irq), .per_req(per_req),
        .per_rdata(per_rdata), .per_ack(rx_ack), .per_wdata(rx_pwd),
        .mem_req(rx_mreq), .mem_we(rx_we), .mem_addr(rx_addr),
        .mem_wdata(rx_mwd), .mem_rdata(mem_rdata), .mem_ack(mem_ack));

    perdma_chan #(.RX_DIR(1'b0)) uut_tx (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ptr_out(tx_ptr), .cnt_out(tx_cnt),
        .eot_flag(tx_eot), .irq(tx_irq), .per_req(per_req),
        .per_rdata(per_rdata), .per_ack(tx_ack), .per_wdata(tx_pwd),
        .mem_req(tx_mreq), .mem_we(tx_we), .mem_addr(tx_addr),
        .mem_wdata(tx_mwd), .mem_rdata(mem_rdata), .mem_ack(mem_ack));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare both channels' register views with the model.
    task automatic chk_regs(input string tag);
        chk({tag, " rx ptr"}, rx_ptr, exp_ptr);
        chk({tag, " tx ptr"}, tx_ptr, exp_ptr);
        chk({tag, " rx cnt"}, {16'd0, rx_cnt}, {16'd0, exp_cnt});
        chk({tag, " tx cnt"}, {16'd0, tx_cnt}, {16'd0, exp_cnt});
        chk({tag, " rx eot"}, {31'd0, rx_eot}, {31'd0, exp_eot});
        chk({tag, " tx eot"}, {31'd0, tx_eot}, {31'd0, exp_eot});
        chk({tag, " R11 irq"}, {31'd0, rx_irq}, {31'd0, exp_eot & exp_ien});
    endtask

    // Register write; called and returns at a falling edge.
    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
        case (sel)
            2'd0: exp_ptr = data;
            2'd1: begin
                exp_cnt = data[15:0];
                if (data[15:0] != 16'd0) exp_eot = 1'b0;
            end
            2'd2: exp_ien = data[0];
            default: ;
        endcase
    endtask

    // One byte transfer with a given memory latency; hold keeps per_req up.
    task automatic xfer(input logic [7:0] d, input int lat, input bit hold);
        logic [7:0] rd;
        per_req = 1'b1; per_rdata = d;
        @(negedge clk);
        chk("R3 rx mem_req", {31'd0, rx_mreq}, 32'd1);
        chk("R3 rx mem_we", {31'd0, rx_we}, 32'd1);
        chk("R3 rx mem_addr", rx_addr, exp_ptr);
        chk("R3 rx mem_wdata", {24'd0, rx_mwd}, {24'd0, d});
        chk("R4 tx mem_req", {31'd0, tx_mreq}, 32'd1);
        chk("R4 tx mem_we", {31'd0, tx_we}, 32'd0);
        chk("R4 tx mem_addr", tx_addr, exp_ptr);
        per_rdata = ~d;
        for (int k = 1; k < lat; k++) begin
            @(negedge clk);
            chk("R7 rx req held", {31'd0, rx_mreq}, 32'd1);
            chk("R7 no early ack", {31'd0, rx_ack}, 32'd0);
        end
        rd = exp_ptr[7:0] ^ 8'hA5;
        mem_ack = 1'b1; mem_rdata = rd;
        @(negedge clk);
        mem_ack = 1'b0; mem_rdata = 8'h00;
        exp_ptr = exp_ptr + 32'd1;
        if (exp_cnt == 16'd1) exp_eot = 1'b1;
        exp_cnt = exp_cnt - 16'd1;
        chk("R5 rx per_ack", {31'd0, rx_ack}, 32'd1);
        chk("R5 tx per_ack", {31'd0, tx_ack}, 32'd1);
        chk("R4 tx per_wdata", {24'd0, tx_pwd}, {24'd0, rd});
        chk("R7 req dropped", {31'd0, rx_mreq}, 32'd0);
        chk_regs("R6 R9 after xfer");
        if (!hold) per_req = 1'b0;
        @(negedge clk);
        chk("R5 ack single", {31'd0, rx_ack}, 32'd0);
        chk("R7 no reaccept in ack cycle", {31'd0, rx_mreq | tx_mreq}, 32'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_regs("R1 reset");
        chk("R1 mem_req", {31'd0, rx_mreq | tx_mreq}, 32'd0);
        chk("R1 per_ack", {31'd0, rx_ack | tx_ack}, 32'd0);

        // R2: register loads and the unused select.
        wr(2'd0, 32'hDEAD_BEEF); chk_regs("R2 ptr load");
        wr(2'd1, 32'hFFFF_0003); chk_regs("R2 cnt load");
        wr(2'd3, 32'h0000_1234); chk_regs("R2 sel3 ignored");
        wr(2'd1, 32'd0);         chk_regs("R2 cnt clear");

        // R8: requests at zero count are ignored.
        per_req = 1'b1; per_rdata = 8'h3C;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R8 no mem_req", {31'd0, rx_mreq | tx_mreq}, 32'd0);
            chk("R8 no ack", {31'd0, rx_ack | tx_ack}, 32'd0);
        end
        per_req = 1'b0;
        chk_regs("R8 state unchanged");

        // Sweep over run lengths, latencies and held/dropped requests.
        wr(2'd2, 32'd1);
        for (int n = 1; n <= 4; n++) begin
            wr(2'd0, 32'h1000_0000 + 32'(n * 256));
            wr(2'd1, 32'(n));
            chk_regs("R10 nonzero load clears eot");
            for (int i = 0; i < n; i++) begin
                xfer(8'(n * 16 + i), (i % 3) + 1, (i < n - 1) && (i % 2 == 0));
                chk("R9 eot only at end", {31'd0, rx_eot}, {31'd0, i == n - 1});
            end
            repeat (3) @(negedge clk);
            chk_regs("R9 eot stays set");
        end

        // R10: zero count write keeps the flag; R11 enable off.
        wr(2'd1, 32'd0);  chk_regs("R10 zero load keeps eot");
        wr(2'd2, 32'd0);  chk_regs("R11 irq masked");
        wr(2'd2, 32'd1);  chk_regs("R11 irq enabled");

        // R6: pointer wraps.
        wr(2'd0, 32'hFFFF_FFFF);
        wr(2'd1, 32'd1);
        xfer(8'h77, 2, 1'b0);
        chk("R6 ptr wrap", rx_ptr, 32'd0);

        // R12: count write collides with a completion.
        wr(2'd0, 32'h0000_0040);
        wr(2'd1, 32'd5);
        per_req = 1'b1; per_rdata = 8'h11;
        @(negedge clk);
        mem_ack = 1'b1; mem_rdata = 8'h22;
        reg_wr_en = 1'b1; reg_sel = 2'd1; reg_wdata = 32'd9;
        @(negedge clk);
        mem_ack = 1'b0; reg_wr_en = 1'b0; per_req = 1'b0;
        exp_cnt = 16'd9; exp_ptr = exp_ptr + 32'd1; exp_eot = 1'b0;
        chk_regs("R12 write wins on count");
        @(negedge clk);

        // R12: count zeroed mid-access does not wrap on completion.
        wr(2'd1, 32'd3);
        per_req = 1'b1;
        @(negedge clk);
        per_req = 1'b0;
        wr(2'd1, 32'd0);
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
        exp_ptr = exp_ptr + 32'd1;
        chk_regs("R12 no count wrap");
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule